// File: doc/BRIEF.md
# Channel Update Word Assembler

This block takes a byte stream from a host link and rebuilds one 32-bit parameter word for each of four satellite signal channels. Each word holds a satellite number, an amplitude, two phase-rollover (wrap) flags and a code phase. The downstream interpolator reads these flags to handle phase rollover. The host sends a complete set of four words once per update epoch, at a 2 kHz rate. The link therefore has to carry at least 32 kbytes per second.

A frame-start marker begins each set. Incoming bytes go into a shadow store, and the channel outputs do not change while a set is still arriving. When the sixteenth byte arrives, all four channel words move to the active registers on the same clock edge, and a one-cycle commit pulse marks the new set. The signal path therefore never sees a mix of two epochs. If a set is cut short by a new frame-start, the block drops the partial data, keeps the previous active set, and pulses an error flag.

Top module: `chan_word_assembler`

## Requirements
- R1: While reset is held and after its release, every channel output field is zero and both `commit` and `frame_err` are low.
- R2: Within each channel word the bytes arrive most significant first. Bits 31:27 are the satellite number, bits 26:20 the amplitude, bits 19:18 the wrap flags and bits 17:0 the code phase.
- R3: The first four bytes of a set form channel 0, the next four form channel 1, and so on up to channel 3. On the flattened output buses, channel i occupies slice i (for example `sat_num[i*5 +: 5]`).
- R4: The active outputs change only on the edge that captures the sixteenth byte of a set, and all four channels change together on that edge. `commit` is high for exactly the one cycle that follows that edge and is low at every other time.
- R5: A frame-start that arrives after 1 to 15 bytes of a set discards those bytes. The active outputs keep their previous values and no commit occurs.
- R6: `frame_err` is high for the one cycle that follows an edge where frame-start was sampled with 1 to 15 bytes of the current set collected. A frame-start with no bytes collected does not raise it, and neither does a frame-start after a completed set.
- R7: A valid byte has no effect on the outputs when it arrives before the first frame-start after reset, or after a completed set and before the next frame-start.
- R8: A byte that is valid in the same cycle as frame-start is taken as byte 0 of the new set.
- R9: Byte strobes need not be consecutive. Idle cycles between the bytes of a set do not change how the bytes are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | `byte_data` holds a byte this cycle |
| byte_data | input | 8 | Incoming link byte |
| frame_start | input | 1 | Marks the start of a new set and resets the byte position |
| sat_num | output | 20 | Satellite number, 5 bits per channel |
| amp | output | 28 | Amplitude, 7 bits per channel |
| wrap | output | 8 | Wrap flags, 2 bits per channel |
| phase | output | 72 | Code phase, 18 bits per channel |
| commit | output | 1 | One-cycle pulse when a new set becomes active |
| frame_err | output | 1 | One-cycle pulse when a partial set is abandoned |

## Verification
The bench builds the block with its default parameters: four channels, 32-bit words, sixteen bytes per set. With sets this short, every abort position from one to fifteen collected bytes can be swept, and each one is followed by a full recovery set. Expected field values come from splitting each generated word at the R2 bit boundaries. Complete sets are sent in three ways: with a separate marker, with the marker on the first byte, and with idle gaps between bytes. Strays sent outside a frame are checked to leave the outputs alone.

// File: rtl/chan_word_assembler.sv
module chan_word_assembler #(
  parameter int NUM_CH = 4,
  parameter int SAT_W  = 5,
  parameter int AMP_W  = 7,
  parameter int WRAP_W = 2,
  parameter int PH_W   = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     byte_vld,
  input  logic [7:0]               byte_data,
  input  logic                     frame_start,
  output logic [NUM_CH*SAT_W-1:0]  sat_num,
  output logic [NUM_CH*AMP_W-1:0]  amp,
  output logic [NUM_CH*WRAP_W-1:0] wrap,
  output logic [NUM_CH*PH_W-1:0]   phase,
  output logic                     commit,
  output logic                     frame_err
);
  localparam int WORD_W = SAT_W + AMP_W + WRAP_W + PH_W;
  localparam int BYTES  = NUM_CH * (WORD_W / 8);
  localparam int ALL_W  = BYTES * 8;
  localparam int SH_W   = ALL_W - 8;
  localparam int CNT_W  = $clog2(BYTES + 1);

  logic [SH_W-1:0]  shadow;
  logic [ALL_W-1:0] active;
  logic [CNT_W-1:0] cnt;
  logic             armed;

  wire              take  = byte_vld && (frame_start || armed);
  wire [CNT_W-1:0]  pos   = frame_start ? '0 : cnt;
  wire              last  = take && (pos == CNT_W'(BYTES - 1));
  wire [ALL_W-1:0]  sh_nx = {shadow, byte_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow    <= '0;
      active    <= '0;
      cnt       <= '0;
      armed     <= 1'b0;
      commit    <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      commit    <= last;
      frame_err <= frame_start && armed && (cnt != '0);
      if (take) shadow <= sh_nx[SH_W-1:0];
      if (last) begin
        active <= sh_nx;
        armed  <= 1'b0;
        cnt    <= '0;
      end else if (frame_start) begin
        armed <= 1'b1;
        cnt   <= byte_vld ? CNT_W'(1) : '0;
      end else if (take) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    wire [WORD_W-1:0] w = active[(NUM_CH-1-i)*WORD_W +: WORD_W];
    assign sat_num[i*SAT_W +: SAT_W]   = w[WORD_W-1 -: SAT_W];
    assign amp[i*AMP_W +: AMP_W]       = w[PH_W+WRAP_W +: AMP_W];
    assign wrap[i*WRAP_W +: WRAP_W]    = w[PH_W +: WRAP_W];
    assign phase[i*PH_W +: PH_W]       = w[PH_W-1:0];
  end
endmodule

// File: rtl/chan_word_assembler_chk.sv
module chan_word_assembler_chk #(
  parameter int OUT_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic             frame_start,
  input logic [OUT_W-1:0] outs,
  input logic             commit,
  input logic             frame_err
);
  p_commit_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  p_hold_between_commits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |-> $stable(outs));

  p_commit_after_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(byte_vld));

  p_err_after_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(frame_start));

  p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  p_no_err_with_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_err && commit));
endmodule

bind chan_word_assembler chan_word_assembler_chk #(
  .OUT_W(NUM_CH*(SAT_W+AMP_W+WRAP_W+PH_W))
) chk_i (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .frame_start(frame_start),
  .outs({sat_num, amp, wrap, phase}), .commit(commit), .frame_err(frame_err)
);

// File: tb/chan_word_assembler_tb_top.sv
module chan_word_assembler_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_vld = 1'b0;
  logic [7:0] byte_data = '0;
  logic frame_start = 1'b0;
  logic [19:0] sat_num;
  logic [27:0] amp;
  logic [7:0]  wrap;
  logic [71:0] phase;
  logic commit, frame_err;

  int total = 0;
  int fails = 0;
  logic [31:0] cur_w [4];

  always #10 clk = ~clk;

  chan_word_assembler dut_i (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .frame_start(frame_start), .sat_num(sat_num), .amp(amp), .wrap(wrap),
    .phase(phase), .commit(commit), .frame_err(frame_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req);
    bit ok = 1'b1;
    for (int c = 0; c < 4; c++) begin
      if (sat_num[c*5 +: 5]   !== cur_w[c][31:27]) ok = 1'b0;
      if (amp[c*7 +: 7]       !== cur_w[c][26:20]) ok = 1'b0;
      if (wrap[c*2 +: 2]      !== cur_w[c][19:18]) ok = 1'b0;
      if (phase[c*18 +: 18]   !== cur_w[c][17:0])  ok = 1'b0;
    end
    chk(ok, req, {sat_num[4:0], amp[6:0], wrap[1:0], phase[17:0]}, cur_w[0]);
  endtask

  task automatic cyc(input bit vld, input logic [7:0] d, input bit fs);
    byte_vld = vld; byte_data = d; frame_start = fs;
    @(negedge clk);
    byte_vld = 1'b0; frame_start = 1'b0;
  endtask

  function automatic logic [31:0] gen(input int k, input int ch);
    logic [31:0] v = 32'(k*4 + ch + 1) * 32'h9E3779B1;
    if (k == 3 && ch == 0) v = 32'hFFFF_FFFF;
    if (k == 3 && ch == 3) v = 32'h0000_0000;
    return v ^ 32'(k << 8);
  endfunction

  task automatic send_set(input int k, input int mode);
    logic [31:0] nw [4];
    for (int c = 0; c < 4; c++) nw[c] = gen(k, c);
    if (mode != 1) cyc(1'b0, 8'h00, 1'b1);
    for (int n = 0; n < 16; n++) begin
      logic [7:0] b = nw[n/4][31 - 8*(n%4) -: 8];
      cyc(1'b1, b, (mode == 1) && (n == 0));
      if (n < 15) begin
        chk(commit === 1'b0, "R4 no commit mid-set", 32'(commit), 0);
        chk_outs("R4 outputs held mid-set");
        if (mode == 2) begin
          cyc(1'b0, 8'hA5, 1'b0);
          cyc(1'b0, 8'h5A, 1'b0);
        end
      end
    end
    for (int c = 0; c < 4; c++) cur_w[c] = nw[c];
    chk(commit === 1'b1, "R4 commit after 16th byte", 32'(commit), 1);
    chk_outs(mode == 1 ? "R8 R2 R3 fields after commit" :
             mode == 2 ? "R9 R2 R3 fields after commit" : "R2 R3 fields after commit");
    cyc(1'b0, 8'h00, 1'b0);
    chk(commit === 1'b0, "R4 commit lasts one cycle", 32'(commit), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) cur_w[c] = '0;
    repeat (3) @(negedge clk);
    chk({sat_num, amp, wrap, phase} === '0, "R1 outputs zero in reset", 32'(sat_num), 0);
    chk(commit === 1'b0 && frame_err === 1'b0, "R1 pulses low in reset", {30'd0, commit, frame_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_outs("R1 outputs zero after reset");

    for (int n = 0; n < 20; n++) begin
      cyc(1'b1, 8'(n * 37 + 1), 1'b0);
      chk(commit === 1'b0, "R7 no commit before first frame", 32'(commit), 0);
    end
    chk_outs("R7 pre-frame bytes ignored");

    send_set(0, 0);
    send_set(1, 1);
    send_set(2, 2);
    send_set(3, 0);

    for (int n = 0; n < 20; n++) begin
      cyc(1'b1, 8'(n * 11 + 3), 1'b0);
      chk(commit === 1'b0 && frame_err === 1'b0, "R7 no pulse after completed set", {30'd0, commit, frame_err}, 0);
    end
    chk_outs("R7 post-set bytes ignored");

    cyc(1'b0, 8'h00, 1'b1);
    cyc(1'b0, 8'h00, 1'b0);
    chk(frame_err === 1'b0, "R6 no error after completed set", 32'(frame_err), 0);
    cyc(1'b0, 8'h00, 1'b1);
    chk(frame_err === 1'b0, "R6 no error with zero bytes collected", 32'(frame_err), 0);

    for (int a = 1; a < 16; a++) begin
      cyc(1'b0, 8'h00, 1'b1);
      for (int n = 0; n < a; n++) cyc(1'b1, 8'(8'hC3 ^ 8'(n * 29 + a)), 1'b0);
      cyc(1'b0, 8'h00, 1'b1);
      chk(frame_err === 1'b1, "R6 error on abort", 32'(frame_err), 1);
      chk(commit === 1'b0, "R5 no commit on abort", 32'(commit), 0);
      chk_outs("R5 outputs kept on abort");
      cyc(1'b0, 8'h00, 1'b0);
      chk(frame_err === 1'b0, "R6 error lasts one cycle", 32'(frame_err), 0);
      send_set(a + 4, a % 3);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule